// File: doc/BRIEF.md
# Windowed Register Index Translator

This block turns an architectural integer register number into an index into a physical register file. The register file serves a processor with overlapping register windows and banked global registers. The block holds two pieces of state: a current window pointer and a global bank level. Control logic writes each of them through its own write-enable and data pair.

From those two registered values the block produces three physical indices at the same time for one architectural number. They belong to the current window, the next window (pointer minus one) and the previous window (pointer plus one). Both neighbour views wrap around the ring of windows. The global registers come from the selected bank, except register zero, which is shared by every bank.

The block also maps a small set of microcode temporary registers into the space above the window ring. All translation is combinational from the registered state, so a write is visible on the cycle after it is made.

With the default parameters there are 8 globals per bank, 4 banks, 8 windows of 16 registers each and 8 temporaries. The physical layout is:
- the global banks at indices 0 to 31;
- the window ring at 32 to 159;
- the temporaries at 160 to 167.

Architectural numbers 0 to 7 are globals. Numbers 8 to 31 are the 24 windowed registers, called offset w = number − 8.

Top module: `wrt_xlate`

## Requirements
- R1: Architectural register 0 maps to physical index 0 in all three views for every bank level and window pointer.
- R2: Architectural register g, with g from 1 to 7, maps to g + 8 × GL in all three views, where GL is the stored bank level.
- R3: Architectural register 8 + w, with w from 0 to 23, maps in the current view to 32 + ((w − 16 × CWP) mod 128), where CWP is the stored window pointer.
- R4: A window pointer write whose 8-bit value is 8 or more stores 7; a value from 0 to 7 is stored unchanged.
- R5: The next view applies the R3 formula with (CWP − 1) mod 8 and the previous view applies it with (CWP + 1) mod 8, so that pointer 0 wraps to 7 and pointer 7 wraps to 0.
- R6: Microcode temporary k, with k from 0 to 7, maps to 160 + k, independent of CWP and GL.
- R7: After reset, CWP and GL are both 0 and all outputs follow from those values.
- R8: A write changes the outputs only after the next rising clock edge. With its write enable low, a state register keeps its value whatever its data input carries.
- R9: The window pointer and the bank level are written independently. They can be written in the same cycle, and writing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cwp_we | input | 1 | Window pointer write enable |
| cwp_wdata | input | 8 | Window pointer write value (clamped) |
| gl_we | input | 1 | Bank level write enable |
| gl_wdata | input | 2 | Bank level write value |
| arch_idx | input | 5 | Architectural register number |
| micro_idx | input | 3 | Microcode temporary number |
| cur_phys | output | 8 | Physical index, current window |
| nxt_phys | output | 8 | Physical index, next window |
| prv_phys | output | 8 | Physical index, previous window |
| micro_phys | output | 8 | Physical index of the temporary |

## Verification
The hardest cases are the wrap points of the window ring. At pointer 0 the next view must reach back to window 7, and at pointer 7 the previous view must come round to window 0. Either wrap is reached only by a write that has been stored, and pointer 7 can also be reached only through the clamp. The bench therefore writes every pointer value from 0 to 15 in combination with every bank level, and after each write it sweeps all 32 architectural numbers through all three views. This covers both wraps, reaching them directly and through clamped writes, and checks each result against arithmetic computed in the bench.

// File: rtl/wrt_pkg.sv
`timescale 1ns/1ps
package wrt_pkg;
    localparam int WRT_NGLOB  = 8;   // globals per bank
    localparam int WRT_NLVL   = 4;   // global bank levels
    localparam int WRT_RPW    = 16;  // registers added per window step
    localparam int WRT_NWIN   = 8;   // windows in the ring
    localparam int WRT_NVIS   = 24;  // windowed registers visible in one view
    localparam int WRT_NMICRO = 8;   // microcode temporaries
    localparam int WRT_WDW    = 8;   // width of the window pointer write data

    // Pointer offset applied by each of the three views.
    function automatic int view_offset(int v);
        case (v)
            1:       return -1;   // next window
            2:       return 1;    // previous window
            default: return 0;    // current window
        endcase
    endfunction
endpackage

// File: rtl/wrt_state.sv
`timescale 1ns/1ps
module wrt_state #(
    parameter int NWIN = 8,
    parameter int NLVL = 4,
    parameter int WDW  = 8,
    localparam int CWPW = $clog2(NWIN),
    localparam int GLW  = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cwp_we,
    input  logic [WDW-1:0]  cwp_wdata,
    input  logic            gl_we,
    input  logic [GLW-1:0]  gl_wdata,
    output logic [CWPW-1:0] cwp_o,
    output logic [GLW-1:0]  gl_o
);
    typedef struct packed {
        logic [CWPW-1:0] cwp;
        logic [GLW-1:0]  gl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cwp_we) begin
            if (cwp_wdata >= WDW'(NWIN))
                st_d.cwp = CWPW'(NWIN - 1);
            else
                st_d.cwp = cwp_wdata[CWPW-1:0];
        end
        if (gl_we)
            st_d.gl = gl_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cwp_o = st_q.cwp;
    assign gl_o  = st_q.gl;

    assert_cwp_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_we && cwp_wdata >= WDW'(NWIN)) |=> (cwp_o == CWPW'(NWIN - 1)));
    assert_cwp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cwp_we |=> $stable(cwp_o));
    assert_gl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gl_we |=> $stable(gl_o));
endmodule

// File: rtl/wrt_view.sv
`timescale 1ns/1ps
module wrt_view #(
    parameter int NGLOB = 8,
    parameter int NLVL  = 4,
    parameter int RPW   = 16,
    parameter int NWIN  = 8,
    parameter int NVIS  = 24,
    parameter int OFF   = 0,
    parameter int PHW   = 8,
    localparam int CWPW  = $clog2(NWIN),
    localparam int GLW   = $clog2(NLVL),
    localparam int ARCHW = $clog2(NGLOB + NVIS),
    localparam int TG    = NGLOB * NLVL,
    localparam int TW    = NWIN * RPW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CWPW-1:0]  cwp,
    input  logic [GLW-1:0]   gl,
    input  logic [ARCHW-1:0] arch,
    output logic [PHW-1:0]   phys
);
    int a_i, ec_i, res_i;

    always_comb begin
        a_i   = int'(arch);
        ec_i  = (int'(cwp) + NWIN + OFF) % NWIN;
        res_i = 0;
        if (a_i < NGLOB) begin
            if (a_i != 0)
                res_i = a_i + int'(gl) * NGLOB;
        end else begin
            res_i = TG + ((a_i - NGLOB - ec_i * RPW + TW) % TW);
        end
        phys = PHW'(res_i);
    end

    assert_g0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (arch == '0) |-> (phys == '0));
    assert_glob_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch) < NGLOB) |-> (int'(phys) < TG));
    assert_win_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch) >= NGLOB) |-> (int'(phys) >= TG && int'(phys) < TG + TW));
endmodule

// File: rtl/wrt_micro.sv
`timescale 1ns/1ps
module wrt_micro #(
    parameter int BASE   = 160,
    parameter int NMICRO = 8,
    parameter int PHW    = 8,
    localparam int MW = $clog2(NMICRO)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [MW-1:0]  idx,
    output logic [PHW-1:0] phys
);
    always_comb begin
        phys = PHW'(BASE + int'(idx));
    end

    assert_micro_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phys) >= BASE && int'(phys) < BASE + NMICRO);
endmodule

// File: rtl/wrt_xlate.sv
`timescale 1ns/1ps
module wrt_xlate
    import wrt_pkg::*;
#(
    parameter int NGLOB  = WRT_NGLOB,
    parameter int NLVL   = WRT_NLVL,
    parameter int RPW    = WRT_RPW,
    parameter int NWIN   = WRT_NWIN,
    parameter int NVIS   = WRT_NVIS,
    parameter int NMICRO = WRT_NMICRO,
    parameter int WDW    = WRT_WDW,
    localparam int TG    = NGLOB * NLVL,
    localparam int TW    = NWIN * RPW,
    localparam int PHW   = $clog2(TG + TW + NMICRO),
    localparam int CWPW  = $clog2(NWIN),
    localparam int GLW   = $clog2(NLVL),
    localparam int ARCHW = $clog2(NGLOB + NVIS),
    localparam int MW    = $clog2(NMICRO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cwp_we,
    input  logic [WDW-1:0]   cwp_wdata,
    input  logic             gl_we,
    input  logic [GLW-1:0]   gl_wdata,
    input  logic [ARCHW-1:0] arch_idx,
    input  logic [MW-1:0]    micro_idx,
    output logic [PHW-1:0]   cur_phys,
    output logic [PHW-1:0]   nxt_phys,
    output logic [PHW-1:0]   prv_phys,
    output logic [PHW-1:0]   micro_phys
);
    logic [CWPW-1:0]       cwp_q;
    logic [GLW-1:0]        gl_q;
    logic [2:0][PHW-1:0]   view_phys;

    wrt_state #(.NWIN(NWIN), .NLVL(NLVL), .WDW(WDW)) u_state (
        .clk(clk), .rst_n(rst_n),
        .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata),
        .cwp_o(cwp_q), .gl_o(gl_q)
    );

    for (genvar v = 0; v < 3; v++) begin : g_view
        wrt_view #(
            .NGLOB(NGLOB), .NLVL(NLVL), .RPW(RPW), .NWIN(NWIN),
            .NVIS(NVIS), .OFF(view_offset(v)), .PHW(PHW)
        ) u_view (
            .clk(clk), .rst_n(rst_n),
            .cwp(cwp_q), .gl(gl_q), .arch(arch_idx),
            .phys(view_phys[v])
        );
    end

    wrt_micro #(.BASE(TG + TW), .NMICRO(NMICRO), .PHW(PHW)) u_micro (
        .clk(clk), .rst_n(rst_n), .idx(micro_idx), .phys(micro_phys)
    );

    assign cur_phys = view_phys[0];
    assign nxt_phys = view_phys[1];
    assign prv_phys = view_phys[2];

    // Neighbouring views sit exactly one window step apart on the ring.
    assert_next_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch_idx) >= NGLOB) |->
        (((int'(nxt_phys) - int'(cur_phys) + TW) % TW) == RPW));
    assert_prev_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch_idx) >= NGLOB) |->
        (((int'(cur_phys) - int'(prv_phys) + TW) % TW) == RPW));
    assert_globals_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(arch_idx) < NGLOB) |-> (cur_phys == nxt_phys && cur_phys == prv_phys));
endmodule

// File: tb/sim_wrt_xlate.sv
`timescale 1ns/1ps
module sim_wrt_xlate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cwp_we = 1'b0;
    logic [7:0] cwp_wdata = '0;
    logic       gl_we = 1'b0;
    logic [1:0] gl_wdata = '0;
    logic [4:0] arch_idx = '0;
    logic [2:0] micro_idx = '0;
    logic [7:0] cur_phys, nxt_phys, prv_phys, micro_phys;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    wrt_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata),
        .arch_idx(arch_idx), .micro_idx(micro_idx),
        .cur_phys(cur_phys), .nxt_phys(nxt_phys),
        .prv_phys(prv_phys), .micro_phys(micro_phys)
    );

    function automatic int exp_idx(int a, int c, int g, int off);
        int ec;
        if (a == 0) return 0;
        if (a < 8) return a + g * 8;
        ec = (c + 8 + off) % 8;
        return 32 + ((a - 8 - ec * 16 + 128) % 128);
    endfunction

    task automatic chk(int got, int exp, string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Sweep every architectural number through the three views.
    task automatic sweep(int c, int g, string tag);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            arch_idx = 5'(a);
            #2;
            if (a == 0) begin
                chk(cur_phys, 0, {tag, " R1 cur"});
                chk(nxt_phys, 0, {tag, " R1 nxt"});
                chk(prv_phys, 0, {tag, " R1 prv"});
            end else if (a < 8) begin
                chk(cur_phys, exp_idx(a, c, g, 0), {tag, " R2 cur"});
                chk(nxt_phys, exp_idx(a, c, g, -1), {tag, " R2 nxt"});
                chk(prv_phys, exp_idx(a, c, g, 1), {tag, " R2 prv"});
            end else begin
                chk(cur_phys, exp_idx(a, c, g, 0), {tag, " R3 cur"});
                chk(nxt_phys, exp_idx(a, c, g, -1), {tag, " R5 nxt"});
                chk(prv_phys, exp_idx(a, c, g, 1), {tag, " R5 prv"});
            end
        end
    endtask

    task automatic micro_sweep(string tag);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            micro_idx = 3'(k);
            #2;
            chk(micro_phys, 160 + k, {tag, " R6 micro"});
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: state after reset is pointer 0, level 0
        sweep(0, 0, "R7 reset");
        micro_sweep("R7 reset");

        // R4 R5 R9: every level with every pointer value, both written together
        for (int g = 0; g < 4; g++) begin
            for (int w = 0; w < 16; w++) begin
                @(negedge clk);
                cwp_we = 1'b1; cwp_wdata = 8'(w);
                gl_we = 1'b1;  gl_wdata = 2'(g);
                @(negedge clk);
                cwp_we = 1'b0; gl_we = 1'b0;
                sweep((w >= 8) ? 7 : w, g, (w >= 8) ? "R4 clamp" : "R9 both");
            end
        end
        // R4: largest write value
        @(negedge clk);
        cwp_we = 1'b1; cwp_wdata = 8'hFF;
        @(negedge clk);
        cwp_we = 1'b0;
        arch_idx = 5'd8;
        #2;
        chk(cur_phys, exp_idx(8, 7, 3, 0), "R4 max value");
        micro_sweep("R6 after writes");

        // R8: write visible only after the next edge (state is ptr 7, level 3)
        @(negedge clk);
        cwp_we = 1'b1; cwp_wdata = 8'd2; arch_idx = 5'd8;
        #2;
        chk(cur_phys, exp_idx(8, 7, 3, 0), "R8 before edge");
        @(negedge clk);
        cwp_we = 1'b0;
        #2;
        chk(cur_phys, exp_idx(8, 2, 3, 0), "R8 after edge");

        // R8: data without enable is ignored
        @(negedge clk);
        cwp_wdata = 8'd5; gl_wdata = 2'd0;
        @(negedge clk);
        @(negedge clk);
        arch_idx = 5'd9;
        #2;
        chk(cur_phys, exp_idx(9, 2, 3, 0), "R8 cwp hold");
        arch_idx = 5'd4;
        #2;
        chk(cur_phys, exp_idx(4, 2, 3, 0), "R8 gl hold");

        // R9: level write alone leaves the pointer
        @(negedge clk);
        gl_we = 1'b1; gl_wdata = 2'd1;
        @(negedge clk);
        gl_we = 1'b0;
        sweep(2, 1, "R9 gl only");

        // R9: pointer write alone leaves the level
        @(negedge clk);
        cwp_we = 1'b1; cwp_wdata = 8'd0;
        @(negedge clk);
        cwp_we = 1'b0;
        sweep(0, 1, "R9 cwp only");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule